// File: doc/BRIEF.md
# Buffer RAM Address Sequencer

This block supplies the address and the control strobes for a 1024-byte buffer RAM that sits on an 8-bit processor port bus. Firmware presets a start address with a single byte write. The byte fills the upper eight address bits, and the two low bits are always filled with binary 10. As a result, a preset can only land on every fourth location.

Each RAM access is framed by the active-low bank select. When an access finishes, which is the cycle in which bank select rises again, the address steps down by one. The step happens after the access has used the address, not before. If an access finishes while the address is zero, the counter wraps to 1023 and an active-low exhaustion flag drops. The flag stays low until the next preset, and firmware reads it as a status bit to end a transfer loop. Chip select is the bank select passed straight through. The RAM read drive and the RAM write pulse are both derived from bank select and the write-phase strobe.

Top module: `buf_addr_counter`

## Requirements
- R1: While `rst` is sampled high, and on the first edge after it, `addr` is 0, `ovf_n` is 1, `ram_we_n` is 1 and `ram_oe_n` is 1.
- R2: An edge that samples `load` high sets `addr` to {`bus_data`, 2'b10}, so a byte value P gives address 4*P+2. The same edge returns `ovf_n` to 1.
- R3: An access finishes on an edge that samples `bank_sel_n` high when the previous edge sampled it low. On that edge `addr` drops by exactly one. On any other edge without `load`, `addr` holds its value.
- R4: If an access finishes while `addr` is 0, `addr` becomes 1023 and `ovf_n` goes low. `ovf_n` then stays low through any further accesses until a load or a reset.
- R5: After a preset of P, `ovf_n` first goes low on the (4*P+3)-th finished access and not earlier.
- R6: `ram_cs_n` follows `bank_sel_n` in the same cycle, with no register in between.
- R7: `ram_oe_n` is low for the cycle after an edge that samples `bank_sel_n` low and also samples `wr_phase` low on both that edge and the one before. Otherwise it is high.
- R8: `ram_we_n` goes low for exactly one cycle after an edge that samples `wr_phase` low when the previous edge sampled it high, provided `bank_sel_n` is low at that edge. With `bank_sel_n` high, no write pulse is produced.
- R9: If `load` and an access finish fall on the same edge, the preset wins and no decrement is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 8 | Port bus byte used as the preset |
| load | input | 1 | Preset strobe |
| bank_sel_n | input | 1 | Active-low RAM bank select; frames each access |
| wr_phase | input | 1 | High while the processor drives the bus |
| addr | output | 10 | RAM address |
| ram_cs_n | output | 1 | RAM chip select (bank select passed through) |
| ram_oe_n | output | 1 | RAM read drive enable, active low |
| ram_we_n | output | 1 | RAM write pulse, active low |
| ovf_n | output | 1 | Active-low exhaustion status |

## Verification
The assertions check the following on every cycle:
- the exact preset value after a load;
- the single-step decrement at the end of each access;
- the wrap from zero that goes with a falling exhaustion flag;
- that the write pulse never lasts more than one cycle;
- that the read drive is only ever produced from a sampled read phase.

Some behaviour only the bench scenarios can show:
- that the flag falls on exactly the expected access count for a given preset;
- that the flag stays low through later accesses;
- that a load beats a finishing access on the same edge;
- that a write-phase fall with the bank deselected produces no write pulse.

// File: rtl/rac_pkg.sv
package rac_pkg;
  localparam logic [1:0] PRESET_LOW_BITS = 2'b10;

  typedef struct packed {
    logic acc_done;
    logic wr_fall;
    logic rd_phase;
  } rac_evt_t;
endpackage

// File: rtl/rac_access_detect.sv
module rac_access_detect
  import rac_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     bank_sel_n,
  input  logic     wr_phase,
  output rac_evt_t evt
);
  logic bank_q;
  logic wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= 1'b1;
      wr_q   <= 1'b0;
    end else begin
      bank_q <= bank_sel_n;
      wr_q   <= wr_phase;
    end
  end

  always_comb begin
    evt.acc_done = ~bank_q & bank_sel_n & ~rst;
    evt.wr_fall  = wr_q & ~wr_phase & ~bank_sel_n & ~rst;
    evt.rd_phase = ~wr_q & ~wr_phase & ~bank_sel_n & ~rst;
  end
endmodule

// File: rtl/rac_counter.sv
module rac_counter
  import rac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              acc_done,
  output logic [ADDR_W-1:0] addr,
  output logic              ovf_n
);
  localparam int LOW_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] preset_val;
  logic              at_zero;

  assign preset_val = {bus_data, PRESET_LOW_BITS[LOW_W-1:0]};
  assign at_zero    = (addr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      ovf_n <= 1'b1;
    end else if (load) begin
      addr  <= preset_val;
      ovf_n <= 1'b1;
    end else if (acc_done) begin
      addr <= addr - ONE;
      if (at_zero) ovf_n <= 1'b0;
    end
  end

  // R2: a load places the byte above the fixed low bits
  assert_preset_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr[ADDR_W-1:LOW_W] == $past(bus_data)) && (addr[LOW_W-1:0] == 2'b10) && ovf_n);

  // R3: one step down per finished access
  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_done && !load) |=> (addr == $past(addr) - ONE));

  // R3: address holds without an event
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!acc_done && !load) |=> $stable(addr));

  // R4: flag only drops on a wrap from zero to the top address
  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_n) |-> (addr == '1));
endmodule

// File: rtl/buf_addr_counter.sv
module buf_addr_counter
  import rac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              load,
  input  logic              bank_sel_n,
  input  logic              wr_phase,
  output logic [ADDR_W-1:0] addr,
  output logic              ram_cs_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic              ovf_n
);
  rac_evt_t evt;

  rac_access_detect u_detect (
    .clk        (clk),
    .rst        (rst),
    .bank_sel_n (bank_sel_n),
    .wr_phase   (wr_phase),
    .evt        (evt)
  );

  rac_counter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .bus_data (bus_data),
    .acc_done (evt.acc_done),
    .addr     (addr),
    .ovf_n    (ovf_n)
  );

  assign ram_cs_n = bank_sel_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_oe_n <= 1'b1;
      ram_we_n <= 1'b1;
    end else begin
      ram_oe_n <= ~evt.rd_phase;
      ram_we_n <= ~evt.wr_fall;
    end
  end

  // R8: write pulse lasts a single cycle
  assert_we_single_R8: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |=> ram_we_n);

  // R8: write pulse only after bank was low on the edge that made it
  assert_we_bank_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_we_n) |-> !$past(bank_sel_n));

  // R7: read drive only follows a sampled read phase
  assert_oe_src_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_oe_n) |-> (!$past(bank_sel_n) && !$past(wr_phase)));

  // R7: read drive and write pulse never overlap
  assert_no_clash_R7: assert property (@(posedge clk) disable iff (rst)
    !(!ram_oe_n && !ram_we_n));
endmodule

// File: tb/buf_addr_counter_bench.sv
module buf_addr_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_data = '0;
  logic       load = 1'b0;
  logic       bank_sel_n = 1'b1;
  logic       wr_phase = 1'b0;
  logic [9:0] addr;
  logic       ram_cs_n, ram_oe_n, ram_we_n, ovf_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  buf_addr_counter u_buf_addr_counter (
    .clk(clk), .rst(rst), .bus_data(bus_data), .load(load),
    .bank_sel_n(bank_sel_n), .wr_phase(wr_phase), .addr(addr),
    .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .ovf_n(ovf_n)
  );

  // {preset byte, accesses, expected addr, expected ovf_n}
  localparam int NV = 9;
  localparam logic [22:0] VEC [NV] = '{
    {8'h00, 4'd0, 10'h002, 1'b1},
    {8'h00, 4'd2, 10'h000, 1'b1},
    {8'h00, 4'd3, 10'h3FF, 1'b0},
    {8'hFF, 4'd0, 10'h3FE, 1'b1},
    {8'hFF, 4'd5, 10'h3F9, 1'b1},
    {8'h01, 4'd6, 10'h000, 1'b1},
    {8'h01, 4'd7, 10'h3FF, 1'b0},
    {8'hA5, 4'd4, 10'h292, 1'b1},
    {8'h01, 4'd9, 10'h3FD, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic after_edge();
    @(posedge clk);
    #2;
  endtask

  task automatic do_load(input logic [7:0] d);
    @(negedge clk);
    load = 1'b1;
    bus_data = d;
    after_edge();
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic rd_access(input bit check_oe);
    @(negedge clk);
    bank_sel_n = 1'b0;
    wr_phase = 1'b0;
    #1;
    if (check_oe) chk("R6 cs_n low", 32'(ram_cs_n), 32'd0);
    after_edge();
    if (check_oe) chk("R7 oe_n low", 32'(ram_oe_n), 32'd0);
    @(negedge clk);
    bank_sel_n = 1'b1;
    after_edge();
    if (check_oe) chk("R7 oe_n released", 32'(ram_oe_n), 32'd1);
  endtask

  task automatic wr_access(input bit check_we);
    @(negedge clk);
    bank_sel_n = 1'b0;
    wr_phase = 1'b1;
    after_edge();
    @(negedge clk);
    wr_phase = 1'b0;
    after_edge();
    if (check_we) begin
      chk("R8 we_n pulse", 32'(ram_we_n), 32'd0);
      chk("R7 no oe during write", 32'(ram_oe_n), 32'd1);
    end
    @(negedge clk);
    bank_sel_n = 1'b1;
    after_edge();
    if (check_we) chk("R8 we_n one cycle", 32'(ram_we_n), 32'd1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [9:0] a0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 addr reset", 32'(addr), 32'd0);
    chk("R1 ovf_n reset", 32'(ovf_n), 32'd1);
    chk("R1 we_n reset", 32'(ram_we_n), 32'd1);
    chk("R1 oe_n reset", 32'(ram_oe_n), 32'd1);
    @(negedge clk);
    rst = 1'b0;
    after_edge();
    chk("R1 addr after release", 32'(addr), 32'd0);
    chk("R6 cs_n idle", 32'(ram_cs_n), 32'd1);

    // table walk: R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      do_load(VEC[i][22:15]);
      chk("R2 preset", 32'(addr), 32'(VEC[i][22:15]) * 4 + 2);
      for (int k = 0; k < int'(VEC[i][14:11]); k++) begin
        if (k[0]) wr_access(k == 1);
        else rd_access(k == 0);
      end
      chk("R3 addr after accesses", 32'(addr), 32'(VEC[i][10:1]));
      chk("R4 ovf_n after accesses", 32'(ovf_n), 32'(VEC[i][0]));
    end

    // R2: load releases flag
    do_load(8'h03);
    chk("R2 ovf_n released", 32'(ovf_n), 32'd1);

    // R5: preset 2 -> flag on access 11, not 10
    do_load(8'h02);
    for (int k = 0; k < 10; k++) rd_access(0);
    chk("R5 no flag at 10", 32'(ovf_n), 32'd1);
    rd_access(0);
    chk("R5 flag at 11", 32'(ovf_n), 32'd0);
    chk("R4 wrap addr", 32'(addr), 32'h3FF);

    // R3 hold without access
    a0 = addr;
    repeat (4) after_edge();
    chk("R3 hold", 32'(addr), 32'(a0));

    // R8: write fall with bank high -> no pulse, no step
    @(negedge clk);
    wr_phase = 1'b1;
    after_edge();
    @(negedge clk);
    wr_phase = 1'b0;
    after_edge();
    chk("R8 no pulse with bank high", 32'(ram_we_n), 32'd1);
    chk("R3 no step with bank high", 32'(addr), 32'(a0));

    // R9: load and access end on same edge
    @(negedge clk);
    bank_sel_n = 1'b0;
    after_edge();
    @(negedge clk);
    bank_sel_n = 1'b1;
    load = 1'b1;
    bus_data = 8'h10;
    after_edge();
    chk("R9 load wins", 32'(addr), 32'h042);
    @(negedge clk);
    load = 1'b0;
    after_edge();
    chk("R9 no late step", 32'(addr), 32'h042);

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    after_edge();
    chk("R1 addr re-reset", 32'(addr), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule